// File: doc/BRIEF.md
# Pulse-and-Verify Word Programmer for One-Time-Programmable Memory

This block copies a run of 16-bit words from a host into an ultraviolet-erasable or one-time-programmable memory. The host gives a start strobe, a base address and a word count. The block then asks for the words one at a time through a request/valid handshake. For each word it first reads the location back. If the word does not yet match, it drives address and data in parallel, enables the programming supply and chip enable, and applies a low-going program strobe of fixed width. It repeats the read and the pulse until the readback equals the target.

A program pulse can only turn bits from 1 to 0, and an erased cell reads 1. A word that asks for a 1 where the location already holds a 0 can never be written, so the block reports it at once and does not pulse it. A word that still fails after the allowed number of pulses is also reported. Both cases stop the run and record the failing address. When a word verifies, the block moves straight on to the next address and applies no extra pulse.

Top module: `eprog_sequencer`

## Requirements
- R1: After reset, busy, done, error and wd_req are 0, err_code is 0, and mem_e_n, mem_p_n and mem_g_n are 1. mem_vpp_en and mem_dq_oe are 0.
- R2: On start in idle, the block latches base_addr and word_count. It fetches word i of the run for address base_addr+i, in ascending order, one fetch per address.
- R3: Each program pulse holds mem_p_n low for exactly PULSE_CYC = CLK_HZ/1000*PULSE_US/1000 clocks. During the pulse mem_e_n is 0 and mem_vpp_en and mem_dq_oe are 1, and mem_addr and mem_dq_out stay constant.
- R4: mem_vpp_en and mem_dq_oe are high for at least one clock before mem_p_n falls. They stay high for at least one clock after mem_p_n rises.
- R5: mem_dq_oe is never 1 while the read strobe mem_g_n is 0. mem_g_n falls only after mem_dq_oe has been 0 for at least one clock.
- R6: Each word is read before any pulse and again after every pulse. Pulsing stops at the first matching read and no extra pulse follows. A word that already matches gets zero pulses.
- R7: If a readback has a 0 where the target has a 1, the run stops with error=1, err_code=1 and err_addr set to that address. That address receives no further pulse and no later word is fetched.
- R8: If a word reaches MAX_PULSES pulses without a matching read, the run stops with error=1, err_code=2 and err_addr set to that address. No word ever gets more than MAX_PULSES pulses.
- R9: After the last word verifies, done=1 and busy=0. A start with word_count 0 sets done without fetching or touching the memory.
- R10: busy is 1 from the clock after an accepted start until done or error is set. done and error stay set until the next start clears them, and a start while busy is ignored.
- R11: wd_req stays 1 until wd_valid is seen, and the block makes no progress while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a run (taken only when idle) |
| base_addr | input | AW | First address of the run |
| word_count | input | AW+1 | Number of words in the run |
| wd_req | output | 1 | Request for the next word |
| wd_valid | input | 1 | Host word is present |
| wd_data | input | DW | Host word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished without fault (sticky) |
| error | output | 1 | Run aborted (sticky) |
| err_code | output | 2 | 1 = unprogrammable bit, 2 = pulse limit reached |
| err_addr | output | AW | Address of the failing word |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DW | Data read from memory |
| mem_e_n | output | 1 | Chip enable, active low |
| mem_p_n | output | 1 | Program strobe, active low |
| mem_g_n | output | 1 | Read (output-enable) strobe, active low |
| mem_vpp_en | output | 1 | Programming-supply enable |

## Verification
The bound checker watches the memory-side timing on every clock. It checks the exact width of each pulse and that address and data hold still under it, the supply and drive setup and hold around each pulse, and that the bus is never driven during a read. It also checks the per-word pulse ceiling, that busy excludes done and error, and that the handshake request is held. Whether the cells really end up holding the targets, whether each word got exactly the pulses it needed, and how an unprogrammable or stubborn word is reported can only be shown by the bench. Its memory model clears bits only on valid pulses and needs a chosen number of pulses per word.

// File: rtl/eprog_pkg.sv
package eprog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_PULSE,
    ST_RECOVER,
    ST_VERIFY,
    ST_NEXT,
    ST_FAIL,
    ST_DONE
  } eprog_state_e;

  typedef enum logic [1:0] {
    RD_TURN   = 2'd0,
    RD_STROBE = 2'd1,
    RD_DECIDE = 2'd2
  } eprog_rd_e;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_ILLEGAL = 2'd1;
  localparam logic [1:0] ERR_EXHAUST = 2'd2;

endpackage

// File: rtl/eprog_phase_timer.sv
module eprog_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/eprog_word_cmp.sv
module eprog_word_cmp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] target,
  input  logic [DW-1:0] readback,
  output logic          match,
  output logic          illegal
);

  logic [DW-1:0] need_set;

  always_comb begin
    need_set = target & ~readback;
    match    = (target == readback);
    illegal  = |need_set;
  end

endmodule

// File: rtl/eprog_addr_track.sv
module eprog_addr_track #(
  parameter int AW = 16,
  parameter int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      remain_q <= '0;
    end else if (init) begin
      addr     <= base;
      remain_q <= count;
    end else if (step) begin
      addr     <= addr + 1'b1;
      remain_q <= remain_q - 1'b1;
    end
  end

  assign last = (remain_q == CW'(1));

endmodule

// File: rtl/eprog_sequencer.sv
module eprog_sequencer
  import eprog_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 16,
  parameter int CLK_HZ     = 125_000_000,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2,
  parameter int READ_CYC   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW:0]   word_count,
  output logic          wd_req,
  input  logic          wd_valid,
  input  logic [DW-1:0] wd_data,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [1:0]    err_code,
  output logic [AW-1:0] err_addr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_e_n,
  output logic          mem_p_n,
  output logic          mem_g_n,
  output logic          mem_vpp_en
);

  localparam int CW        = AW + 1;
  localparam int PULSE_CYC = CLK_HZ / 1000 * PULSE_US / 1000;
  localparam int TW        = $clog2(PULSE_CYC + SETUP_CYC + HOLD_CYC + READ_CYC + 1);
  localparam int PCW       = $clog2(MAX_PULSES + 1);

  eprog_state_e  st_q, st_n;
  eprog_rd_e     rd_q, rd_n;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;
  logic          accept, step, run_init, pulse_inc, capture;
  logic [1:0]    fail_code;
  logic [DW-1:0] target_q, readback_q;
  logic [PCW-1:0] pcnt_q;
  logic          w_match, w_illegal, at_last;
  logic          start_ok;

  assign start_ok = start && (st_q == ST_IDLE);
  assign run_init = start_ok;

  eprog_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  eprog_word_cmp #(.DW(DW)) u_cmp (
    .target   (target_q),
    .readback (readback_q),
    .match    (w_match),
    .illegal  (w_illegal)
  );

  eprog_addr_track #(.AW(AW), .CW(CW)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .init  (run_init),
    .base  (base_addr),
    .count (word_count),
    .step  (step),
    .addr  (mem_addr),
    .last  (at_last)
  );

  // next-state and phase-timer control
  always_comb begin
    st_n      = st_q;
    rd_n      = rd_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    accept    = 1'b0;
    step      = 1'b0;
    pulse_inc = 1'b0;
    capture   = 1'b0;
    fail_code = ERR_NONE;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          st_n = (word_count == '0) ? ST_DONE : ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (wd_req && wd_valid) begin
          accept   = 1'b1;
          st_n     = ST_VERIFY;
          rd_n     = RD_TURN;
          tmr_load = 1'b1;
          tmr_val  = '0;
        end
      end
      ST_VERIFY: begin
        if (tmr_done) begin
          unique case (rd_q)
            RD_TURN: begin
              rd_n     = RD_STROBE;
              tmr_load = 1'b1;
              tmr_val  = TW'(READ_CYC - 1);
            end
            RD_STROBE: begin
              capture  = 1'b1;
              rd_n     = RD_DECIDE;
              tmr_load = 1'b1;
              tmr_val  = '0;
            end
            default: begin
              if (w_match) begin
                st_n = ST_NEXT;
              end else if (w_illegal) begin
                st_n      = ST_FAIL;
                fail_code = ERR_ILLEGAL;
              end else if (pcnt_q == PCW'(MAX_PULSES)) begin
                st_n      = ST_FAIL;
                fail_code = ERR_EXHAUST;
              end else begin
                st_n     = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETUP_CYC - 1);
              end
            end
          endcase
        end
      end
      ST_SETUP: begin
        if (tmr_done) begin
          st_n      = ST_PULSE;
          pulse_inc = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = TW'(PULSE_CYC - 1);
        end
      end
      ST_PULSE: begin
        if (tmr_done) begin
          st_n     = ST_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = TW'(HOLD_CYC - 1);
        end
      end
      ST_RECOVER: begin
        if (tmr_done) begin
          st_n     = ST_VERIFY;
          rd_n     = RD_TURN;
          tmr_load = 1'b1;
          tmr_val  = '0;
        end
      end
      ST_NEXT: begin
        step = 1'b1;
        st_n = at_last ? ST_DONE : ST_FETCH;
      end
      ST_FAIL: st_n = ST_IDLE;
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  // state, datapath and registered outputs (decoded from next state)
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      rd_q       <= RD_TURN;
      target_q   <= '0;
      readback_q <= '0;
      pcnt_q     <= '0;
      wd_req     <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
      err_code   <= ERR_NONE;
      err_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      mem_e_n    <= 1'b1;
      mem_p_n    <= 1'b1;
      mem_g_n    <= 1'b1;
      mem_vpp_en <= 1'b0;
    end else begin
      st_q <= st_n;
      rd_q <= rd_n;
      if (accept) begin
        target_q   <= wd_data;
        mem_dq_out <= wd_data;
        pcnt_q     <= '0;
      end else if (pulse_inc) begin
        pcnt_q <= pcnt_q + 1'b1;
      end
      if (capture) begin
        readback_q <= mem_dq_in;
      end
      if (start_ok) begin
        done     <= 1'b0;
        error    <= 1'b0;
        err_code <= ERR_NONE;
      end
      if (st_n == ST_DONE) begin
        done <= 1'b1;
      end
      if (st_n == ST_FAIL) begin
        error    <= 1'b1;
        err_code <= fail_code;
        err_addr <= mem_addr;
      end
      wd_req     <= (st_n == ST_FETCH);
      busy       <= !(st_n inside {ST_IDLE, ST_DONE, ST_FAIL});
      mem_e_n    <= (st_n inside {ST_IDLE, ST_DONE, ST_FAIL});
      mem_vpp_en <= (st_n inside {ST_SETUP, ST_PULSE, ST_RECOVER});
      mem_dq_oe  <= (st_n inside {ST_SETUP, ST_PULSE, ST_RECOVER});
      mem_p_n    <= (st_n != ST_PULSE);
      mem_g_n    <= !((st_n == ST_VERIFY) && (rd_n == RD_STROBE));
    end
  end

endmodule

// File: rtl/eprog_checker.sv
module eprog_checker #(
  parameter int DW         = 16,
  parameter int AW         = 16,
  parameter int PULSE_CYC  = 12500,
  parameter int MAX_PULSES = 25
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          wd_req,
  input logic          wd_valid,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe,
  input logic          mem_e_n,
  input logic          mem_p_n,
  input logic          mem_g_n,
  input logic          mem_vpp_en
);

  int   low_cnt;
  int   word_pulses;
  logic p_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt     <= 0;
      word_pulses <= 0;
      p_prev      <= 1'b1;
    end else begin
      p_prev  <= mem_p_n;
      low_cnt <= mem_p_n ? 0 : low_cnt + 1;
      if (wd_req && wd_valid) begin
        word_pulses <= 0;
      end else if (!mem_p_n && p_prev) begin
        word_pulses <= word_pulses + 1;
      end
    end
  end

  assert_no_drive_in_read_R5: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_g_n));
  assert_read_turnaround_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_g_n) |-> !$past(mem_dq_oe));
  assert_pulse_conditions_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_p_n |-> (mem_vpp_en && !mem_e_n && mem_dq_oe));
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_p_n) |-> (low_cnt == PULSE_CYC));
  assert_pulse_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_p_n && !$past(mem_p_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
  assert_pulse_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_p_n) |-> ($past(mem_vpp_en) && $past(mem_dq_oe)));
  assert_pulse_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_p_n) |-> (mem_vpp_en && mem_dq_oe));
  assert_pulse_limit_R8: assert property (@(posedge clk) disable iff (rst)
    word_pulses <= MAX_PULSES);
  assert_busy_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(busy && (done || error)));
  assert_busy_needs_start_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_req_within_run_R11: assert property (@(posedge clk) disable iff (rst)
    wd_req |-> busy);
  assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
    (wd_req && !wd_valid) |=> wd_req);

endmodule

bind eprog_sequencer eprog_checker #(
  .DW(DW), .AW(AW), .PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES)
) u_eprog_checker (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .wd_req     (wd_req),
  .wd_valid   (wd_valid),
  .busy       (busy),
  .done       (done),
  .error      (error),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe),
  .mem_e_n    (mem_e_n),
  .mem_p_n    (mem_p_n),
  .mem_g_n    (mem_g_n),
  .mem_vpp_en (mem_vpp_en)
);

// File: tb/test_eprog_sequencer.sv
`timescale 1ns/1ps
module test_eprog_sequencer;

  localparam int DW         = 16;
  localparam int AW         = 16;
  localparam int CLK_HZ     = 200_000;
  localparam int PULSE_US   = 100;
  localparam int MAX_PULSES = 6;
  localparam int PULSE_CYC  = CLK_HZ / 1000 * PULSE_US / 1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW:0]   word_count = '0;
  logic          wd_req;
  logic          wd_valid = 1'b0;
  logic [DW-1:0] wd_data = '0;
  logic          busy, done, error;
  logic [1:0]    err_code;
  logic [AW-1:0] err_addr, mem_addr;
  logic [DW-1:0] mem_dq_out, mem_dq_in;
  logic          mem_dq_oe, mem_e_n, mem_p_n, mem_g_n, mem_vpp_en;

  int total = 0;
  int bad   = 0;

  // behavioural memory model
  logic [DW-1:0] mem   [256];
  int            need  [256];
  int            hits  [256];
  int            pulses[256];
  int            low_c = 0;
  logic          prev_p = 1'b1;
  int            pulse_cond_bad = 0, width_bad = 0, bus_bad = 0;

  // host word source
  logic [DW-1:0] src   [16];
  int            src_idx = 0;
  int            src_delay = 0;
  int            fetches = 0;
  int            stall_bad = 0;

  always #4 clk = ~clk;

  eprog_sequencer #(
    .DW(DW), .AW(AW), .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US), .MAX_PULSES(MAX_PULSES),
    .SETUP_CYC(2), .HOLD_CYC(2), .READ_CYC(2)
  ) i_eprog_sequencer (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .word_count(word_count),
    .wd_req(wd_req), .wd_valid(wd_valid), .wd_data(wd_data),
    .busy(busy), .done(done), .error(error), .err_code(err_code), .err_addr(err_addr),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_e_n(mem_e_n), .mem_p_n(mem_p_n), .mem_g_n(mem_g_n), .mem_vpp_en(mem_vpp_en)
  );

  assign mem_dq_in = (!mem_e_n && !mem_g_n && !mem_dq_oe) ? mem[mem_addr[7:0]] : 16'hDEAD;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_p_n) begin
        if (mem_vpp_en && !mem_e_n && mem_dq_oe) low_c++;
        else pulse_cond_bad++;
      end else if (!prev_p) begin
        pulses[mem_addr[7:0]]++;
        if (low_c != PULSE_CYC) width_bad++;
        else begin
          hits[mem_addr[7:0]]++;
          if (hits[mem_addr[7:0]] >= need[mem_addr[7:0]])
            mem[mem_addr[7:0]] = mem[mem_addr[7:0]] & mem_dq_out;
        end
        low_c = 0;
      end
      if (mem_dq_oe && !mem_g_n) bus_bad++;
      prev_p = mem_p_n;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (wd_req && !wd_valid) begin
        for (int k = 0; k < src_delay; k++) begin
          @(negedge clk);
          if (!wd_req) stall_bad++;
        end
        wd_data  = src[src_idx];
        wd_valid = 1'b1;
        src_idx++;
        fetches++;
      end else if (wd_valid && !wd_req) begin
        wd_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 256; i++) begin
      mem[i] = '1; need[i] = 1; hits[i] = 0; pulses[i] = 0;
    end
    pulse_cond_bad = 0; width_bad = 0; bus_bad = 0; stall_bad = 0;
    src_idx = 0; fetches = 0;
  endtask

  task automatic run(input int base, input int n, input int dly, input bit poke_busy);
    src_delay = dly;
    @(negedge clk);
    base_addr  = AW'(base);
    word_count = (AW+1)'(n);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      repeat (30) @(negedge clk);
      base_addr = AW'(8'hF0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && !error) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 busy/done/error", !busy && !done && !error && err_code == 0, {busy, done, error}, 0);
    check("R1 strobes idle", mem_e_n && mem_p_n && mem_g_n && !mem_vpp_en && !mem_dq_oe && !wd_req,
          {mem_e_n, mem_p_n, mem_g_n, mem_vpp_en, mem_dq_oe, wd_req}, 6'b111000);
  endtask

  task automatic t_program_random();
    int base = 8'h20;
    model_clear();
    for (int i = 0; i < 8; i++) begin
      src[i] = DW'($urandom_range(0, 16'hFFFE));
      need[base + i] = $urandom_range(1, 4);
    end
    run(base, 8, 0, 1'b1);
    check("R9 done after run", done && !error && !busy, {done, error, busy}, 3'b100);
    check("R10 start while busy ignored", fetches == 8, fetches, 8);
    for (int i = 0; i < 8; i++) begin
      check("R2 word contents", mem[base + i] == src[i], mem[base + i], src[i]);
      check("R6 pulse count", pulses[base + i] == need[base + i], pulses[base + i], need[base + i]);
    end
    check("R2 beyond run untouched", mem[base + 8] == 16'hFFFF && pulses[base + 8] == 0, mem[base + 8], 16'hFFFF);
    check("R3 pulse width", width_bad == 0, width_bad, 0);
    check("R3 pulse conditions", pulse_cond_bad == 0, pulse_cond_bad, 0);
    check("R5 bus drive during read", bus_bad == 0, bus_bad, 0);
    check("R10 done sticky", done, done, 1);
  endtask

  task automatic t_already_written();
    int base = 8'h30;
    model_clear();
    src[0] = 16'h1234; mem[base]     = 16'h1234;
    src[1] = 16'hFFFF;
    src[2] = 16'hF00F; mem[base + 2] = 16'hFF0F; need[base + 2] = 3;
    run(base, 3, 0, 1'b0);
    check("R6 matching word no pulse", pulses[base] == 0, pulses[base], 0);
    check("R6 erased target no pulse", pulses[base + 1] == 0, pulses[base + 1], 0);
    check("R6 partial word pulses", pulses[base + 2] == 3 && mem[base + 2] == 16'hF00F, pulses[base + 2], 3);
    check("R9 done", done && !error, {done, error}, 2'b10);
  endtask

  task automatic t_illegal_word();
    int base = 8'h40;
    model_clear();
    src[0] = 16'hAAAA; src[1] = 16'h5555; src[2] = 16'h0F0F; src[3] = 16'h1111; src[4] = 16'h2222;
    mem[base + 2] = 16'h00FF;
    run(base, 5, 0, 1'b0);
    check("R7 error flagged", error && !done && !busy, {error, done, busy}, 3'b100);
    check("R7 err_code illegal", err_code == 2'd1, err_code, 1);
    check("R7 err_addr", err_addr == AW'(base + 2), err_addr, base + 2);
    check("R7 no pulse on bad word", pulses[base + 2] == 0 && mem[base + 2] == 16'h00FF, pulses[base + 2], 0);
    check("R7 run aborted", fetches == 3 && mem[base + 3] == 16'hFFFF, fetches, 3);
    check("R7 earlier words written", mem[base] == 16'hAAAA && mem[base + 1] == 16'h5555, mem[base + 1], 16'h5555);
  endtask

  task automatic t_pulse_limit();
    int base = 8'h60;
    model_clear();
    src[0] = 16'h0000; src[1] = 16'h1234;
    need[base] = 100;
    run(base, 2, 0, 1'b0);
    check("R8 error flagged", error && !done, {error, done}, 2'b10);
    check("R8 err_code exhaust", err_code == 2'd2, err_code, 2);
    check("R8 err_addr", err_addr == AW'(base), err_addr, base);
    check("R8 exact pulse ceiling", pulses[base] == MAX_PULSES, pulses[base], MAX_PULSES);
    repeat (10) @(negedge clk);
    check("R10 error sticky", error && !busy, {error, busy}, 2'b10);
  endtask

  task automatic t_zero_count();
    model_clear();
    run(8'h70, 0, 0, 1'b0);
    check("R9 empty run done", done && !error, {done, error}, 2'b10);
    check("R9 empty run no fetch", fetches == 0, fetches, 0);
    check("R10 start clears error", err_code == 0, err_code, 0);
  endtask

  task automatic t_slow_host();
    int base = 8'h80;
    model_clear();
    src[0] = 16'h8001; src[1] = 16'h7FFE; src[2] = 16'h0000;
    need[base] = 2; need[base + 1] = 1; need[base + 2] = 4;
    run(base, 3, 7, 1'b0);
    check("R11 request held while stalled", stall_bad == 0, stall_bad, 0);
    for (int i = 0; i < 3; i++) begin
      check("R11 words after stall", mem[base + i] == src[i] && pulses[base + i] == need[base + i],
            mem[base + i], src[i]);
    end
    check("R4 no pulse outside setup", pulse_cond_bad == 0, pulse_cond_bad, 0);
  endtask

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program_random();
    t_already_written();
    t_illegal_word();
    t_pulse_limit();
    t_zero_count();
    t_slow_host();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule